// File: doc/BRIEF.md
# Microcontroller Reset Source Controller

This block merges every reset cause of a small 8-bit microcontroller into one sequenced system reset. A power-on indication starts a two-phase stretch. It holds the system in reset for a long phase and then a short phase. It then releases reset and marks two vector-fetch cycles, which present the high and low halves of the reset vector address.

While the core runs, the block qualifies several reset causes. These are a watchdog overflow, an illegal opcode, a STOP instruction that the option bit forbids, an opcode fetch from an unmapped address, and a low level on the external reset pin. Each cause has a qualifier: fetch type, option bits, or debug-mode high-voltage conditions. A qualified cause starts a short internal reset. During that reset the block drives the open-drain pin low when the cause is internal. It also logs the cause in a one-hot status register, which software clears by reading it.

The watchdog disable is purely combinational. It follows the monitor-mode and break-state qualifiers together with the high-voltage detect flags.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is 1. After `por_i` falls, `sys_rst_o` stays 1 for exactly POR_LONG_CYC (4096) clock edges and then INT_CYC (32) more edges. `rst_pin_pd_o` is 1 only during the last INT_CYC of those edges.
- R2: In the cycle after reset is released, `vec_fetch_o` is 1 and `vec_addr_o` is 16'hFFFE. In the next cycle, `vec_fetch_o` is 1 and `vec_addr_o` is 16'hFFFF. After that, `vec_fetch_o` is 0 and `vec_addr_o` is 0.
- R3: A `wdog_ovf_i` sampled high in run state, with `wdog_dis_o` low, gives an internal reset. `sys_rst_o` rises after that edge and holds for 32 cycles, with `rst_pin_pd_o` high for all 32 cycles. Status bit 2 (watchdog) is then set.
- R4: `illegal_op_i` gives the same 32-cycle reset with pulldown and sets status bit 1 (illegal opcode). So does `stop_exec_i` while `stop_en_i` is 0. `stop_exec_i` while `stop_en_i` is 1 has no effect.
- R5: `unmapped_i` together with `opc_fetch_i` gives a 32-cycle reset with pulldown and sets status bit 0 (illegal address). `unmapped_i` without `opc_fetch_i` has no effect.
- R6: The pin is sampled through two flops. A low pin seen in run state gives a 32-cycle reset with `rst_pin_pd_o` held at 0 and sets status bit 3 (pin). `sys_rst_o` rises in the third cycle after the pin goes low.
- R7: `wdog_dis_o` is 1 when `monitor_i` is high and either `hv_rst_i` or `hv_irq_i` is high. It is also 1 when `break_i` and `hv_rst_i` are both high. It is 0 otherwise. A watchdog overflow while `wdog_dis_o` is 1 has no effect.
- R8: `status_o` holds one-hot flags: [4] power-on, [3] pin, [2] watchdog, [1] illegal opcode, [0] illegal address. A power-on sets only bit 4. Any other reset sets only its own bit. `status_rd_i` clears all bits at the next edge. A cause on the same edge as a read takes precedence over the clear.
- R9: Any cause that arrives while a reset or the vector-fetch cycles are in progress is ignored. It neither changes the status nor lengthens the sequence.
- R10: When causes coincide, the watchdog wins over illegal opcode, which wins over illegal address, which wins over the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| rst_pin_n_i | input | 1 | Sensed level of the open-drain reset pin, active low |
| wdog_ovf_i | input | 1 | Watchdog counter overflow |
| opc_fetch_i | input | 1 | CPU is fetching an opcode this cycle |
| illegal_op_i | input | 1 | CPU decoded an illegal instruction |
| stop_exec_i | input | 1 | CPU is executing STOP |
| stop_en_i | input | 1 | Option bit that permits STOP |
| unmapped_i | input | 1 | Current bus address is unmapped |
| monitor_i | input | 1 | Monitor mode active |
| break_i | input | 1 | Break state active |
| hv_rst_i | input | 1 | High-voltage level detected on the reset pin |
| hv_irq_i | input | 1 | High-voltage level detected on the IRQ pin |
| status_rd_i | input | 1 | CPU read of the status register |
| sys_rst_o | output | 1 | Internal system reset |
| rst_pin_pd_o | output | 1 | Pulldown enable for the reset pin |
| wdog_dis_o | output | 1 | Watchdog disable |
| status_o | output | 5 | Reset cause flags |
| vec_fetch_o | output | 1 | Reset vector fetch in progress |
| vec_addr_o | output | 16 | Vector address during the fetch, else 0 |

## Verification
Suppose the phase counter or the phase state goes wrong. The system reset or the pulldown then ends a cycle early or late, and the vector cycles move with it. That mismatch appears on the first cycle where the edges differ, so no more than one reset length after the cause.

A wrong cause selection or a wrong qualifier shows in the next cycle. It appears either as an unexpected rise of the system reset or as a wrong one-hot status pattern. A missed or spurious clear shows on `status_o` right after the read edge.

Because every output is compared on every cycle, each of these faults is caught on the cycle where it first becomes visible.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int STAT_W  = 5;
  localparam int B_ILAD  = 0;
  localparam int B_ILOP  = 1;
  localparam int B_COP   = 2;
  localparam int B_PIN   = 3;
  localparam int B_POR   = 4;

  typedef enum logic [2:0] {
    PH_POR_LONG,
    PH_POR_SHORT,
    PH_INT,
    PH_VEC0,
    PH_VEC1,
    PH_RUN
  } phase_e;

  typedef enum logic [2:0] {
    CZ_NONE,
    CZ_COP,
    CZ_ILOP,
    CZ_ILAD,
    CZ_PIN,
    CZ_POR
  } cause_e;

  function automatic logic [STAT_W-1:0] flag_of(input cause_e c);
    logic [STAT_W-1:0] f;
    f = '0;
    case (c)
      CZ_COP:  f[B_COP]  = 1'b1;
      CZ_ILOP: f[B_ILOP] = 1'b1;
      CZ_ILAD: f[B_ILAD] = 1'b1;
      CZ_PIN:  f[B_PIN]  = 1'b1;
      CZ_POR:  f[B_POR]  = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction

  function automatic logic wdog_block(input logic mon, input logic brk,
                                      input logic hv_rst, input logic hv_irq);
    return (mon & (hv_rst | hv_irq)) | (brk & hv_rst);
  endfunction

  function automatic cause_e pick_cause(input logic cop, input logic ilop,
                                        input logic ilad, input logic pin);
    if (cop)       return CZ_COP;
    else if (ilop) return CZ_ILOP;
    else if (ilad) return CZ_ILAD;
    else if (pin)  return CZ_PIN;
    else           return CZ_NONE;
  endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge arst)
        if (arst) sh <= RESET_VAL;
        else      sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or posedge arst)
        if (arst) sh <= {STAGES{RESET_VAL}};
        else      sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
  import rsc_pkg::*;
(
  input  logic   clk,
  input  logic   por_i,
  input  logic   wdog_ovf_i,
  input  logic   opc_fetch_i,
  input  logic   illegal_op_i,
  input  logic   stop_exec_i,
  input  logic   stop_en_i,
  input  logic   unmapped_i,
  input  logic   monitor_i,
  input  logic   break_i,
  input  logic   hv_rst_i,
  input  logic   hv_irq_i,
  input  logic   pin_low_i,
  output cause_e cause_o,
  output logic   wdog_dis_o
);
  logic cop_hit, stop_as_ill, ilop_hit, ilad_hit;

  assign wdog_dis_o  = wdog_block(monitor_i, break_i, hv_rst_i, hv_irq_i);
  assign cop_hit     = wdog_ovf_i & ~wdog_dis_o;
  assign stop_as_ill = stop_exec_i & ~stop_en_i;
  assign ilop_hit    = illegal_op_i | stop_as_ill;
  assign ilad_hit    = opc_fetch_i & unmapped_i;
  assign cause_o     = pick_cause(cop_hit, ilop_hit, ilad_hit, pin_low_i);

  AST_DATA_ACCESS_QUIET: assert property (@(posedge clk) disable iff (por_i)
    (unmapped_i && !opc_fetch_i && !wdog_ovf_i && !illegal_op_i && !stop_exec_i && !pin_low_i)
      |-> (cause_o == CZ_NONE)); // R5

  AST_STOP_PERMITTED_QUIET: assert property (@(posedge clk) disable iff (por_i)
    (stop_exec_i && stop_en_i && !wdog_ovf_i && !illegal_op_i && !unmapped_i && !pin_low_i)
      |-> (cause_o == CZ_NONE)); // R4

endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int          POR_LONG_CYC = 4096,
  parameter int          INT_CYC      = 32,
  parameter logic [15:0] VEC_BASE     = 16'hFFFE
) (
  input  logic              clk,
  input  logic              por_i,
  input  cause_e            cause_i,
  input  logic              status_rd_i,
  output logic              sys_rst_o,
  output logic              rst_pin_pd_o,
  output logic              vec_fetch_o,
  output logic [15:0]       vec_addr_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int MAX_CYC = (POR_LONG_CYC > INT_CYC) ? POR_LONG_CYC : INT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              int_from_pin;
  logic [STAT_W-1:0] status_q;

  logic take_cause, long_done, short_done, busy;

  assign take_cause = (phase == PH_RUN) && (cause_i != CZ_NONE);
  assign long_done  = (cnt == CNT_W'(POR_LONG_CYC - 1));
  assign short_done = (cnt == CNT_W'(INT_CYC - 1));

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      phase        <= PH_POR_LONG;
      cnt          <= '0;
      int_from_pin <= 1'b0;
    end else begin
      case (phase)
        PH_POR_LONG: begin
          if (long_done) begin
            phase <= PH_POR_SHORT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_POR_SHORT, PH_INT: begin
          if (short_done) begin
            phase <= PH_VEC0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_VEC0: phase <= PH_VEC1;
        PH_VEC1: phase <= PH_RUN;
        PH_RUN: begin
          if (take_cause) begin
            phase        <= PH_INT;
            cnt          <= '0;
            int_from_pin <= (cause_i == CZ_PIN);
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)            status_q <= flag_of(CZ_POR);
    else if (take_cause)  status_q <= flag_of(cause_i);
    else if (status_rd_i) status_q <= '0;
  end

  always_comb begin
    sys_rst_o    = (phase == PH_POR_LONG) || (phase == PH_POR_SHORT) || (phase == PH_INT);
    rst_pin_pd_o = (phase == PH_POR_SHORT) || ((phase == PH_INT) && !int_from_pin);
    vec_fetch_o  = (phase == PH_VEC0) || (phase == PH_VEC1);
    case (phase)
      PH_VEC0: vec_addr_o = VEC_BASE;
      PH_VEC1: vec_addr_o = VEC_BASE | 16'h0001;
      default: vec_addr_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign busy     = sys_rst_o | vec_fetch_o;

  AST_PD_INSIDE_RESET: assert property (@(posedge clk) disable iff (por_i)
    rst_pin_pd_o |-> sys_rst_o); // R3

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (por_i)
    $onehot0(status_o)); // R8

  AST_VEC_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (por_i)
    (vec_fetch_o && vec_addr_o == VEC_BASE) |=> (vec_fetch_o && vec_addr_o == (VEC_BASE | 16'h0001))); // R2

  AST_RELEASE_INTO_VEC: assert property (@(posedge clk) disable iff (por_i)
    $fell(sys_rst_o) |-> (vec_fetch_o && vec_addr_o == VEC_BASE)); // R2

  AST_STATUS_HELD_BUSY: assert property (@(posedge clk) disable iff (por_i)
    (busy && $past(busy) && !$past(status_rd_i)) |-> $stable(status_o)); // R9

endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
  import rsc_pkg::*;
#(
  parameter int          POR_LONG_CYC = 4096,
  parameter int          INT_CYC      = 32,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [15:0] VEC_BASE     = 16'hFFFE
) (
  input  logic        clk,
  input  logic        por_i,
  input  logic        rst_pin_n_i,
  input  logic        wdog_ovf_i,
  input  logic        opc_fetch_i,
  input  logic        illegal_op_i,
  input  logic        stop_exec_i,
  input  logic        stop_en_i,
  input  logic        unmapped_i,
  input  logic        monitor_i,
  input  logic        break_i,
  input  logic        hv_rst_i,
  input  logic        hv_irq_i,
  input  logic        status_rd_i,
  output logic        sys_rst_o,
  output logic        rst_pin_pd_o,
  output logic        wdog_dis_o,
  output logic [4:0]  status_o,
  output logic        vec_fetch_o,
  output logic [15:0] vec_addr_o
);
  logic   pin_sync_n;
  logic   pin_low;
  cause_e cause;

  rsc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .arst (por_i),
    .d    (rst_pin_n_i),
    .q    (pin_sync_n)
  );

  assign pin_low = ~pin_sync_n;

  rsc_cause u_cause (
    .clk          (clk),
    .por_i        (por_i),
    .wdog_ovf_i   (wdog_ovf_i),
    .opc_fetch_i  (opc_fetch_i),
    .illegal_op_i (illegal_op_i),
    .stop_exec_i  (stop_exec_i),
    .stop_en_i    (stop_en_i),
    .unmapped_i   (unmapped_i),
    .monitor_i    (monitor_i),
    .break_i      (break_i),
    .hv_rst_i     (hv_rst_i),
    .hv_irq_i     (hv_irq_i),
    .pin_low_i    (pin_low),
    .cause_o      (cause),
    .wdog_dis_o   (wdog_dis_o)
  );

  rsc_seq #(.POR_LONG_CYC(POR_LONG_CYC), .INT_CYC(INT_CYC), .VEC_BASE(VEC_BASE)) u_seq (
    .clk          (clk),
    .por_i        (por_i),
    .cause_i      (cause),
    .status_rd_i  (status_rd_i),
    .sys_rst_o    (sys_rst_o),
    .rst_pin_pd_o (rst_pin_pd_o),
    .vec_fetch_o  (vec_fetch_o),
    .vec_addr_o   (vec_addr_o),
    .status_o     (status_o)
  );

  AST_COP_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (por_i)
    (!sys_rst_o && !vec_fetch_o && wdog_ovf_i && wdog_dis_o && !illegal_op_i
     && !(opc_fetch_i && unmapped_i) && pin_sync_n) |=> !sys_rst_o); // R7

endmodule

// File: tb/tb_rst_source_ctrl.sv
module tb_rst_source_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_N     = 4096;
  localparam int SHORT_N    = 32;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic por = 1'b1, ext_low = 1'b0;
  logic wdog = 0, fetch = 0, ill = 0, stp = 0, stp_en = 0, unm = 0;
  logic mon = 0, brk = 0, hvr = 0, hvi = 0, rd = 0;
  logic sys_rst, pd, wdis, vfetch;
  logic [4:0]  stat;
  logic [15:0] vaddr;
  wire  pin_n = !(ext_low || pd);

  int n_vec = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference model
  int   m_phase;   // 0 long, 1 short, 2 internal, 3 vecA, 4 vecB, 5 run
  int   m_rem;
  bit   m_pinrst;
  logic [4:0] m_stat;
  bit   m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_source_ctrl dut (
    .clk(clk), .por_i(por), .rst_pin_n_i(pin_n), .wdog_ovf_i(wdog),
    .opc_fetch_i(fetch), .illegal_op_i(ill), .stop_exec_i(stp), .stop_en_i(stp_en),
    .unmapped_i(unm), .monitor_i(mon), .break_i(brk), .hv_rst_i(hvr), .hv_irq_i(hvi),
    .status_rd_i(rd), .sys_rst_o(sys_rst), .rst_pin_pd_o(pd), .wdog_dis_o(wdis),
    .status_o(stat), .vec_fetch_o(vfetch), .vec_addr_o(vaddr)
  );

  function automatic bit e_rst();   return m_phase <= 2; endfunction
  function automatic bit e_pd();    return (m_phase == 1) || (m_phase == 2 && !m_pinrst); endfunction
  function automatic bit e_vf();    return (m_phase == 3) || (m_phase == 4); endfunction
  function automatic logic [15:0] e_va();
    if (m_phase == 3) return 16'hFFFE;
    if (m_phase == 4) return 16'hFFFF;
    return 16'h0000;
  endfunction
  function automatic bit e_dis();   return (mon && (hvr || hvi)) || (brk && hvr); endfunction

  task automatic cmp(string what, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s at t=%0t: got %h expected %h", cur_req, what, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (por) begin
      m_phase = 0; m_rem = LONG_N; m_stat = 5'b10000; m_pinrst = 0;
      m_q = {1'b1, 1'b1};
    end else begin
      bit pin_now, seen, dis;
      int code;
      pin_now = !(ext_low || e_pd());
      seen = m_q[0];
      if (m_phase == 5) begin
        dis = e_dis();
        code = -1;
        if (wdog && !dis)             code = 2;
        else if (ill || (stp && !stp_en)) code = 1;
        else if (fetch && unm)        code = 0;
        else if (!seen)               code = 3;
        if (code >= 0) begin
          m_stat = 5'(1 << code); m_phase = 2; m_rem = SHORT_N; m_pinrst = (code == 3);
        end else if (rd) m_stat = 5'b0;
      end else begin
        if (rd) m_stat = 5'b0;
        case (m_phase)
          0: begin m_rem--; if (m_rem == 0) begin m_phase = 1; m_rem = SHORT_N; end end
          1, 2: begin m_rem--; if (m_rem == 0) m_phase = 3; end
          3: m_phase = 4;
          default: m_phase = 5;
        endcase
      end
      void'(m_q.pop_front());
      m_q.push_back(pin_now);
    end
    #(CLK_PERIOD/4);
    cmp("sys_rst", 16'(sys_rst), 16'(e_rst()));
    cmp("pulldown", 16'(pd), 16'(e_pd()));
    cmp("status", 16'(stat), 16'(m_stat));
    cmp("vec_fetch", 16'(vfetch), 16'(e_vf()));
    cmp("vec_addr", vaddr, e_va());
    cmp("wdog_dis", 16'(wdis), 16'(e_dis()));
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    // R1 R8: reset state and power-on stretch
    cur_req = "R1"; idle(3);
    por = 0;
    idle(LONG_N + SHORT_N - 2);
    cur_req = "R2"; idle(6);
    // R8: read clears status
    cur_req = "R8"; rd = 1; idle(1); rd = 0; idle(3);
    // R3: watchdog reset with pulldown
    cur_req = "R3"; wdog = 1; idle(1); wdog = 0; idle(40);
    // R7: disable combinations and ignored overflow
    cur_req = "R7"; mon = 1; hvr = 1; idle(1); wdog = 1; idle(1); wdog = 0; idle(3);
    hvr = 0; hvi = 1; idle(2); mon = 0; brk = 1; idle(2); hvr = 1; idle(2);
    wdog = 1; idle(1); wdog = 0; idle(2); hvi = 0; idle(1); brk = 0; hvr = 0; idle(3);
    // R4: illegal opcode and STOP qualification
    cur_req = "R4"; ill = 1; idle(1); ill = 0; idle(40);
    stp_en = 1; stp = 1; idle(1); stp = 0; idle(3);
    stp_en = 0; stp = 1; idle(1); stp = 0; idle(40);
    // R5: unmapped data access vs opcode fetch
    cur_req = "R5"; unm = 1; idle(2); unm = 0; idle(3);
    fetch = 1; unm = 1; idle(1); fetch = 0; unm = 0; idle(40);
    // R9: causes during a running sequence
    cur_req = "R9"; wdog = 1; idle(1); wdog = 0; idle(5);
    ill = 1; idle(1); ill = 0; idle(3); ext_low = 1; idle(2); ext_low = 0;
    idle(24); fetch = 1; unm = 1; idle(1); fetch = 0; unm = 0; idle(1);
    ill = 1; idle(1); ill = 0; idle(10);
    // R6: external pin reset, no pulldown
    cur_req = "R6"; ext_low = 1; idle(3); ext_low = 0; idle(45);
    // R10: coinciding causes
    cur_req = "R10"; wdog = 1; ill = 1; fetch = 1; unm = 1; idle(1);
    wdog = 0; ill = 0; fetch = 0; unm = 0; idle(40);
    ill = 1; fetch = 1; unm = 1; idle(1); ill = 0; fetch = 0; unm = 0; idle(40);
    fetch = 1; unm = 1; ext_low = 1; idle(1); fetch = 0; unm = 0; ext_low = 0; idle(40);
    // R8: cause on the same edge as a read wins
    cur_req = "R8"; wdog = 1; rd = 1; idle(1); wdog = 0; rd = 0; idle(40);
    rd = 1; idle(1); rd = 0; idle(2);
    // R1: power-on again in the middle of operation
    cur_req = "R1"; por = 1; idle(2); por = 0; idle(LONG_N + SHORT_N + 6);
    finish_run();
  end
endmodule